// File: doc/BRIEF.md
# Synchronous Integer Neuron Datapath

This block computes the activation of a single artificial neuron built from unsigned integer arithmetic. Four unsigned input samples are each multiplied by their own unsigned weight. Each product is captured in a product register, and that register loads only on a clock edge where the update strobe is high. The four held products are added at full width, so the sum cannot overflow. The sum is then normalised by a logical right shift of a fixed number of places. The result drives a level output and is compared against a programmable threshold to produce a registered firing flag.

The learning state is kept in counters. Each weight sits in a saturating up/down counter that a pair of adjust strobes steps. A prediction counter advances on every cycle in which the neuron is firing. Because products are only captured when update is high, a surrounding controller can change the weights or the inputs freely and then commit a new evaluation in a single chosen cycle.

Top module: `neuron_core`

## Requirements
- R1: A synchronous reset clears every product register, every weight (to 0), the firing flag and the prediction counter, so the cycle after reset shows level 0, fire 0, weights 0 and predCount 0.
- R2: On a rising edge with update high, the product register of synapse i loads x_i times w_i. Here x_i is xIn[i*IN_W +: IN_W], and w_i is the weight held before that edge, as seen on weights[i*WT_W +: WT_W].
- R3: On an edge with update low, all product registers keep their values, so level does not change even when xIn or the weights change.
- R4: level equals the sum of the four held products, taken at full width (product width plus 2 bits), shifted right by SHIFT. With all inputs and weights at their maximum this gives 4*(2^IN_W-1)*(2^WT_W-1) >> SHIFT.
- R5: fire is registered. After each edge it equals (level >= threshold) as it was in the cycle before that edge, and equality counts as firing.
- R6: wtInc[i] high with wtDec[i] low adds 1 to weight i. At 2^WT_W-1 the weight stays put.
- R7: wtDec[i] high with wtInc[i] low subtracts 1 from weight i. At 0 the weight stays put.
- R8: wtInc[i] and wtDec[i] high together leave weight i unchanged.
- R9: predCount adds 1 on each edge where fire is high, wraps modulo 2^CNT_W, and holds while fire is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| update | input | 1 | Load enable for the product registers |
| wtInc | input | 4 | Per-synapse weight increment strobes |
| wtDec | input | 4 | Per-synapse weight decrement strobes |
| xIn | input | 4*IN_W | Four packed inputs, synapse i at [i*IN_W +: IN_W] |
| threshold | input | IN_W+WT_W+2-SHIFT | Firing threshold compared with level |
| level | output | IN_W+WT_W+2-SHIFT | Normalised sum of the held products |
| fire | output | 1 | Registered firing flag |
| weights | output | 4*WT_W | Packed weight counters, synapse i at [i*WT_W +: WT_W] |
| predCount | output | CNT_W | Prediction counter |

## Verification
The assertions check on every cycle that level holds while update is low, that fire follows the previous cycle's comparison, and that the prediction counter steps only when fire is high. They also check every weight counter's step direction, its saturation at both ends, and that it holds when both strobes are high. Only the bench scenarios can show that the products themselves are right: the values across a sweep of input patterns, the all-ones maximum, the inclusive threshold boundary, and the counter wrap after several hundred firing cycles. For these the bench compares against a model computed arithmetically.

// File: rtl/neuron_pkg.sv
package neuron_pkg;
  localparam int NUM_SYN = 4;

  typedef struct packed {
    logic               clr;
    logic               loadProd;
    logic [NUM_SYN-1:0] wtUp;
    logic [NUM_SYN-1:0] wtDown;
  } neuron_strobe_t;
endpackage

// File: rtl/neuron_ctrl.sv
module neuron_ctrl
  import neuron_pkg::*;
(
  input  logic               rst,
  input  logic               update,
  input  logic [NUM_SYN-1:0] wtInc,
  input  logic [NUM_SYN-1:0] wtDec,
  output neuron_strobe_t     strobe
);
  // conflicting adjust requests cancel to a hold
  always_comb begin
    strobe.clr      = rst;
    strobe.loadProd = update & ~rst;
    strobe.wtUp     = wtInc & ~wtDec;
    strobe.wtDown   = wtDec & ~wtInc;
  end
endmodule

// File: rtl/neuron_synapse.sv
module neuron_synapse #(
  parameter int IN_W = 4,
  parameter int WT_W = 3,
  localparam int PW  = IN_W + WT_W
) (
  input  logic            clk,
  input  logic            clr,
  input  logic            load,
  input  logic            up,
  input  logic            down,
  input  logic [IN_W-1:0] x,
  output logic [WT_W-1:0] weight,
  output logic [PW-1:0]   prod
);
  localparam logic [WT_W-1:0] WMAX = {WT_W{1'b1}};

  logic [PW-1:0] prodNext;
  assign prodNext = PW'(x) * PW'(weight);

  always_ff @(posedge clk) begin
    if (clr) begin
      prod <= '0;
    end else if (load) begin
      prod <= prodNext;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      weight <= '0;
    end else if (up && weight != WMAX) begin
      weight <= weight + 1'b1;
    end else if (down && weight != '0) begin
      weight <= weight - 1'b1;
    end
  end
endmodule

// File: rtl/neuron_datapath.sv
module neuron_datapath
  import neuron_pkg::*;
#(
  parameter int IN_W  = 4,
  parameter int WT_W  = 3,
  parameter int SHIFT = 1,
  parameter int CNT_W = 8,
  localparam int PW   = IN_W + WT_W,
  localparam int SW   = PW + 2,
  localparam int QW   = SW - SHIFT
) (
  input  logic                    clk,
  input  neuron_strobe_t          strobe,
  input  logic [NUM_SYN*IN_W-1:0] xIn,
  input  logic [QW-1:0]           threshold,
  output logic [QW-1:0]           level,
  output logic                    fire,
  output logic [NUM_SYN*WT_W-1:0] weights,
  output logic [CNT_W-1:0]        predCount
);
  logic [PW-1:0] prodArr [NUM_SYN];

  for (genvar i = 0; i < NUM_SYN; i++) begin : g_syn
    neuron_synapse #(.IN_W(IN_W), .WT_W(WT_W)) syn_i (
      .clk   (clk),
      .clr   (strobe.clr),
      .load  (strobe.loadProd),
      .up    (strobe.wtUp[i]),
      .down  (strobe.wtDown[i]),
      .x     (xIn[i*IN_W +: IN_W]),
      .weight(weights[i*WT_W +: WT_W]),
      .prod  (prodArr[i])
    );
  end

  // two-level adder tree, widened so no carry is lost
  logic [SW-2:0] pairLo, pairHi;
  logic [SW-1:0] sumAll, shifted;
  assign pairLo  = (SW-1)'(prodArr[0]) + (SW-1)'(prodArr[1]);
  assign pairHi  = (SW-1)'(prodArr[2]) + (SW-1)'(prodArr[3]);
  assign sumAll  = SW'(pairLo) + SW'(pairHi);
  assign shifted = sumAll >> SHIFT;
  assign level   = shifted[QW-1:0];

  always_ff @(posedge clk) begin
    if (strobe.clr) begin
      fire      <= 1'b0;
      predCount <= '0;
    end else begin
      fire <= (level >= threshold);
      if (fire) predCount <= predCount + 1'b1;
    end
  end
endmodule

// File: rtl/neuron_core.sv
module neuron_core
  import neuron_pkg::*;
#(
  parameter int IN_W  = 4,
  parameter int WT_W  = 3,
  parameter int SHIFT = 1,
  parameter int CNT_W = 8,
  localparam int QW   = IN_W + WT_W + 2 - SHIFT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    update,
  input  logic [NUM_SYN-1:0]      wtInc,
  input  logic [NUM_SYN-1:0]      wtDec,
  input  logic [NUM_SYN*IN_W-1:0] xIn,
  input  logic [QW-1:0]           threshold,
  output logic [QW-1:0]           level,
  output logic                    fire,
  output logic [NUM_SYN*WT_W-1:0] weights,
  output logic [CNT_W-1:0]        predCount
);
  neuron_strobe_t strobe;

  neuron_ctrl ctrl_i (
    .rst   (rst),
    .update(update),
    .wtInc (wtInc),
    .wtDec (wtDec),
    .strobe(strobe)
  );

  neuron_datapath #(
    .IN_W(IN_W), .WT_W(WT_W), .SHIFT(SHIFT), .CNT_W(CNT_W)
  ) dp_i (
    .clk      (clk),
    .strobe   (strobe),
    .xIn      (xIn),
    .threshold(threshold),
    .level    (level),
    .fire     (fire),
    .weights  (weights),
    .predCount(predCount)
  );
endmodule

// File: rtl/neuron_core_chk.sv
module neuron_core_chk
  import neuron_pkg::*;
#(
  parameter int IN_W  = 4,
  parameter int WT_W  = 3,
  parameter int SHIFT = 1,
  parameter int CNT_W = 8,
  localparam int QW   = IN_W + WT_W + 2 - SHIFT
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    update,
  input logic [NUM_SYN-1:0]      wtInc,
  input logic [NUM_SYN-1:0]      wtDec,
  input logic [QW-1:0]           threshold,
  input logic [QW-1:0]           level,
  input logic                    fire,
  input logic [NUM_SYN*WT_W-1:0] weights,
  input logic [CNT_W-1:0]        predCount
);
  localparam logic [WT_W-1:0] WMAX = {WT_W{1'b1}};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (level == '0 && !fire && predCount == '0 && weights == '0));

  p_hold_level_r3: assert property (@(posedge clk) disable iff (rst)
    !update |=> $stable(level));

  p_fire_reg_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> fire == $past(level >= threshold));

  p_pred_step_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> predCount == CNT_W'($past(predCount) + 1'b1));

  p_pred_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(predCount));

  for (genvar i = 0; i < NUM_SYN; i++) begin : g_wt
    p_inc_step_r6: assert property (@(posedge clk) disable iff (rst)
      (wtInc[i] && !wtDec[i] && weights[i*WT_W +: WT_W] != WMAX)
      |=> weights[i*WT_W +: WT_W] == WT_W'($past(weights[i*WT_W +: WT_W]) + 1'b1));
    p_inc_sat_r6: assert property (@(posedge clk) disable iff (rst)
      (wtInc[i] && !wtDec[i] && weights[i*WT_W +: WT_W] == WMAX)
      |=> weights[i*WT_W +: WT_W] == WMAX);
    p_dec_step_r7: assert property (@(posedge clk) disable iff (rst)
      (wtDec[i] && !wtInc[i] && weights[i*WT_W +: WT_W] != '0)
      |=> weights[i*WT_W +: WT_W] == WT_W'($past(weights[i*WT_W +: WT_W]) - 1'b1));
    p_dec_sat_r7: assert property (@(posedge clk) disable iff (rst)
      (wtDec[i] && !wtInc[i] && weights[i*WT_W +: WT_W] == '0)
      |=> weights[i*WT_W +: WT_W] == '0);
    p_both_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (wtInc[i] && wtDec[i]) |=> $stable(weights[i*WT_W +: WT_W]));
  end
endmodule

bind neuron_core neuron_core_chk #(
  .IN_W(IN_W), .WT_W(WT_W), .SHIFT(SHIFT), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .update(update), .wtInc(wtInc), .wtDec(wtDec),
  .threshold(threshold), .level(level), .fire(fire), .weights(weights),
  .predCount(predCount)
);

// File: tb/neuron_core_tb_top.sv
module neuron_core_tb_top;
  localparam int IN_W  = 4;
  localparam int WT_W  = 3;
  localparam int SHIFT = 1;
  localparam int CNT_W = 8;
  localparam int NS    = 4;
  localparam int QW    = IN_W + WT_W + 2 - SHIFT;
  localparam int WMAXI = (1 << WT_W) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst;
  logic              update;
  logic [NS-1:0]     wtInc, wtDec;
  logic [NS*IN_W-1:0] xIn;
  logic [QW-1:0]     threshold;
  logic [QW-1:0]     level;
  logic              fire;
  logic [NS*WT_W-1:0] weights;
  logic [CNT_W-1:0]  predCount;

  neuron_core #(.IN_W(IN_W), .WT_W(WT_W), .SHIFT(SHIFT), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .update(update), .wtInc(wtInc), .wtDec(wtDec),
    .xIn(xIn), .threshold(threshold), .level(level), .fire(fire),
    .weights(weights), .predCount(predCount)
  );

  int total = 0;
  int bad   = 0;
  int mW [NS];
  int mP [NS];
  int mFire = 0;
  int mPred = 0;

  function automatic int mLevel();
    int s = 0;
    for (int i = 0; i < NS; i++) s += mP[i];
    return s >> SHIFT;
  endfunction

  function automatic int wOf(int i);
    return int'(weights[i*WT_W +: WT_W]);
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // advance the model by one edge, then compare every output
  task automatic tick();
    int oldLvl  = mLevel();
    int oldFire = mFire;
    if (rst) begin
      for (int i = 0; i < NS; i++) begin mW[i] = 0; mP[i] = 0; end
      mFire = 0;
      mPred = 0;
    end else begin
      for (int i = 0; i < NS; i++)
        if (update) mP[i] = int'(xIn[i*IN_W +: IN_W]) * mW[i];
      for (int i = 0; i < NS; i++) begin
        if (wtInc[i] && !wtDec[i] && mW[i] < WMAXI) mW[i]++;
        else if (wtDec[i] && !wtInc[i] && mW[i] > 0) mW[i]--;
      end
      mFire = (oldLvl >= int'(threshold)) ? 1 : 0;
      mPred = (mPred + oldFire) % (1 << CNT_W);
    end
    @(posedge clk);
    #1;
    check("R2/R4 level", int'(level), mLevel());
    check("R5 fire", int'(fire), mFire);
    for (int i = 0; i < NS; i++) check("R6/R7/R8 weight", wOf(i), mW[i]);
    check("R9 predCount", int'(predCount), mPred);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [NS*IN_W-1:0] pats [10];
  int saved;

  initial begin
    for (int i = 0; i < NS; i++) begin mW[i] = 0; mP[i] = 0; end
    pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'h1234; pats[3] = 16'h8421;
    pats[4] = 16'hF0F0; pats[5] = 16'h0F0F; pats[6] = 16'h7777; pats[7] = 16'hA5A5;
    pats[8] = 16'h0001; pats[9] = 16'hFFFE;
    rst = 1'b1; update = 1'b0; wtInc = '0; wtDec = '0; xIn = '0; threshold = '0;
    repeat (2) tick();
    check("R1 level", int'(level), 0);
    check("R1 fire", int'(fire), 0);
    check("R1 weights", int'(weights), 0);
    check("R1 predCount", int'(predCount), 0);

    rst = 1'b0; threshold = QW'(100);
    wtInc = 4'hF;
    repeat (9) tick();
    wtInc = '0;
    for (int i = 0; i < NS; i++) check("R6 saturate high", wOf(i), WMAXI);

    wtDec = 4'b0010;
    repeat (10) tick();
    wtDec = '0;
    check("R7 saturate low", wOf(1), 0);
    wtInc = 4'b0010;
    repeat (7) tick();
    wtInc = '0;

    update = 1'b1; xIn = '1;
    tick();
    update = 1'b0;
    check("R4 all-ones max", int'(level), (4 * 15 * WMAXI) >> SHIFT);
    tick();

    wtDec = 4'b0100;
    repeat (2) tick();
    wtInc = 4'b0100;
    repeat (3) tick();
    wtInc = '0; wtDec = '0;
    check("R8 both strobes hold", wOf(2), WMAXI - 2);

    update = 1'b1;
    for (int k = 0; k < 10; k++) begin
      xIn = pats[k];
      repeat (2) tick();
    end
    for (int v = 0; v < 16; v++) begin
      xIn = {4'(v), 4'(v ^ 15), 4'(v * 3), 4'(v + 7)};
      wtInc = 4'(v); wtDec = 4'(v >> 1);
      tick();
    end
    wtInc = '0; wtDec = '0;
    xIn = 16'h9C3E;
    tick();

    update = 1'b0;
    saved = int'(level);
    xIn = '1; wtInc = 4'b0001;
    repeat (3) tick();
    wtInc = '0;
    check("R3 level held", int'(level), saved);

    threshold = level;
    tick();
    check("R5 equal fires", int'(fire), 1);
    threshold = level + 1'b1;
    tick();
    check("R5 above no fire", int'(fire), 0);

    threshold = '0;
    repeat (300) tick();
    check("R9 wrapped count", int'(predCount), mPred);

    rst = 1'b1;
    tick();
    rst = 1'b0;
    check("R1 mid-run reset", int'(level) + int'(fire) + int'(predCount) + int'(weights), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule